// File: doc/BRIEF.md
# Two-Bank Chained Interrupt Arbiter

This block holds the interrupt state for sixteen request lines split into two chained banks of eight. Bank 0 is the primary bank and bank 1 is the secondary bank. The secondary bank's output enters the primary bank on line 2, so a request presented on input 2 is recorded against line 9. The block keeps a request bit, an in-service bit and an edge/level trigger bit for every line. From these bits it derives a registered pending flag and the vector of the highest-priority unmasked request.

A consumer reads the pending flag and the vector. It then returns that vector on the acknowledge input. The block maps the vector back to a line through the base vector of each bank and moves that request into service. An edge-triggered line drops its request on acknowledge. A level-triggered line keeps it. Software reaches the trigger-mode bytes through a small byte-wide port with a one-bit bank select.

Top module: `irq_chain_arbiter`

## Requirements
- R1: A synchronous active-high reset clears all request, in-service and trigger-mode bits. After reset, `pending`, `vec_valid`, `vec_out`, `in_service` and `cfg_rdata` read zero.
- R2: `pending` is high one cycle after the state holds any line whose request bit is set and whose mask bit is clear. Lines 0-7 are masked by `mask_b0`[0-7] and lines 8-15 by `mask_b1`[0-7]. Otherwise `pending` is low.
- R3: The winning line is the lowest-numbered line that is requested and unmasked, so any bank-0 line beats every bank-1 line.
- R4: `vec_out` equals the bank's base vector plus the line's index within the bank (0-7), modulo 256. It is registered together with `vec_valid`. `vec_valid` is low when no line qualifies.
- R5: A raise or lower event on input 2 acts on line 9. Line 2's own request bit never becomes set.
- R6: An acknowledged vector in [`base_b0`, `base_b0`+7] selects line (vector & 7). Otherwise, a vector in [`base_b1`, `base_b1`+7] selects line 8 + (vector & 7). Any other vector changes no state.
- R7: An acknowledge sets the selected line's in-service bit only if that line is currently requested and unmasked. Otherwise it has no effect. In-service bits are cleared only by reset.
- R8: On an accepted acknowledge, the request bit is cleared when the line's trigger bit is 0 (edge) and kept when it is 1 (level).
- R9: Trigger-mode byte b is written by `cfg_we` with `cfg_sel`=b, where b is 0 for bank 0 and 1 for bank 1. Bit k of the byte controls line 8*b+k. `cfg_rdata` shows byte `cfg_sel` one cycle later.
- R10: A lower event clears a line's request bit. A raise event on the same cycle as a lower or an accepted acknowledge of that line leaves the request bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_raise | input | 16 | One-cycle raise events, one per line |
| req_lower | input | 16 | One-cycle lower events, one per line |
| mask_b0 | input | 8 | Mask for lines 0-7 (1 = masked) |
| mask_b1 | input | 8 | Mask for lines 8-15 (1 = masked) |
| base_b0 | input | 8 | Base vector of bank 0 |
| base_b1 | input | 8 | Base vector of bank 1 |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vec | input | 8 | Vector being acknowledged |
| cfg_we | input | 1 | Trigger-mode byte write strobe |
| cfg_sel | input | 1 | Trigger-mode byte select (bank) |
| cfg_wdata | input | 8 | Trigger-mode write data |
| cfg_rdata | output | 8 | Registered trigger-mode read data |
| pending | output | 1 | Any unmasked request held |
| vec_valid | output | 1 | `vec_out` holds a winning vector |
| vec_out | output | 8 | Vector of the winning request |
| in_service | output | 16 | In-service bits, line order |

## Verification
The priority scan is driven with single requests, with requests in both banks at once, and with the bank-0 winner masked away. These patterns show whether bank 0 really outranks bank 1 and whether the mask reaches the scan. Acknowledges are sent for out-of-range vectors, for masked lines and for edge and level lines. These cases separate the range mapping, the qualification gate and the trigger-dependent request clear. Cascade redirection and raise/acknowledge collisions on one line are exercised separately, and every clock is compared against a behavioural model.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int BANK_LINES = 8;
  localparam int NUM_BANKS  = 2;
  localparam int VEC_W      = 8;
  localparam int LINES      = BANK_LINES * NUM_BANKS;
  localparam int IDX_W      = $clog2(BANK_LINES);
  localparam int SEL_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W     = 8,
  parameter int VW    = 8,
  parameter int IW    = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  raise,
  input  logic [W-1:0]  lower,
  input  logic [W-1:0]  mask,
  input  logic [VW-1:0] base,
  input  logic [VW-1:0] ack_vec,
  input  logic          ack_take,
  input  logic          trig_we,
  input  logic [W-1:0]  trig_wdata,
  output logic [W-1:0]  live,
  output logic          in_range,
  output logic [W-1:0]  isr,
  output logic [W-1:0]  trig
);
  logic [W-1:0]  req_q, req_n, isr_q, isr_n, trig_q;
  logic [IW-1:0] idx;
  logic [VW:0]   lo_w, hi_w, av_w;

  assign idx      = ack_vec[IW-1:0];
  assign lo_w     = {1'b0, base};
  assign hi_w     = lo_w + (VW+1)'(W - 1);
  assign av_w     = {1'b0, ack_vec};
  assign in_range = (av_w >= lo_w) && (av_w <= hi_w);
  assign live     = req_q & ~mask;

  always_comb begin
    req_n = req_q;
    isr_n = isr_q;
    if (ack_take && live[idx]) begin
      isr_n[idx] = 1'b1;
      if (!trig_q[idx]) req_n[idx] = 1'b0;
    end
    req_n = (req_n & ~lower) | raise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      isr_q  <= '0;
      trig_q <= '0;
    end else begin
      req_q <= req_n;
      isr_q <= isr_n;
      if (trig_we) trig_q <= trig_wdata;
    end
  end

  assign isr  = isr_q;
  assign trig = trig_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NB = 2,
  parameter int W  = 8,
  parameter int VW = 8
) (
  input  logic [NB*W-1:0]  live,
  input  logic [NB*VW-1:0] bases,
  output logic             found,
  output logic [VW-1:0]    vec
);
  always_comb begin
    found = 1'b0;
    vec   = '0;
    for (int i = NB*W-1; i >= 0; i--) begin
      if (live[i]) begin
        found = 1'b1;
        vec   = bases[(i / W)*VW +: VW] + VW'(i % W);
      end
    end
  end
endmodule

// File: rtl/irq_chain_arbiter.sv
module irq_chain_arbiter
  import irq_chain_pkg::*;
#(
  parameter int CASC_IN  = 2,
  parameter int CASC_OUT = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] req_raise,
  input  logic [LINES-1:0] req_lower,
  input  logic [7:0]       mask_b0,
  input  logic [7:0]       mask_b1,
  input  logic [VEC_W-1:0] base_b0,
  input  logic [VEC_W-1:0] base_b1,
  input  logic             ack_valid,
  input  logic [VEC_W-1:0] ack_vec,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  output logic             pending,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_out,
  output logic [LINES-1:0] in_service
);
  logic [LINES-1:0]           raise_eff, lower_eff, live_all, isr_all;
  logic [NUM_BANKS*VEC_W-1:0] bases;
  logic [LINES-1:0]           masks;
  logic [NUM_BANKS-1:0]       hit, take;
  logic [BANK_LINES-1:0]      trig_arr [NUM_BANKS];
  logic                       pick_found;
  logic [VEC_W-1:0]           pick_vec;

  assign bases = {base_b1, base_b0};
  assign masks = {mask_b1, mask_b0};

  // cascade input: events on CASC_IN are recorded on CASC_OUT
  always_comb begin
    raise_eff = req_raise;
    lower_eff = req_lower;
    raise_eff[CASC_OUT] = req_raise[CASC_OUT] | req_raise[CASC_IN];
    lower_eff[CASC_OUT] = req_lower[CASC_OUT] | req_lower[CASC_IN];
    raise_eff[CASC_IN]  = 1'b0;
    lower_eff[CASC_IN]  = 1'b0;
  end

  // first bank whose range holds the vector takes the acknowledge
  always_comb begin
    take = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (ack_valid && hit[b] && (take == '0)) take[b] = 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_bank #(.W(BANK_LINES), .VW(VEC_W), .IW(IDX_W)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .raise      (raise_eff[b*BANK_LINES +: BANK_LINES]),
      .lower      (lower_eff[b*BANK_LINES +: BANK_LINES]),
      .mask       (masks[b*BANK_LINES +: BANK_LINES]),
      .base       (bases[b*VEC_W +: VEC_W]),
      .ack_vec    (ack_vec),
      .ack_take   (take[b]),
      .trig_we    (cfg_we && (cfg_sel == SEL_W'(b))),
      .trig_wdata (cfg_wdata),
      .live       (live_all[b*BANK_LINES +: BANK_LINES]),
      .in_range   (hit[b]),
      .isr        (isr_all[b*BANK_LINES +: BANK_LINES]),
      .trig       (trig_arr[b])
    );
  end

  irq_pick #(.NB(NUM_BANKS), .W(BANK_LINES), .VW(VEC_W)) u_pick (
    .live  (live_all),
    .bases (bases),
    .found (pick_found),
    .vec   (pick_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
      cfg_rdata <= '0;
    end else begin
      pending   <= |live_all;
      vec_valid <= pick_found;
      vec_out   <= pick_found ? pick_vec : '0;
      cfg_rdata <= trig_arr[cfg_sel];
    end
  end

  assign in_service = isr_all;
endmodule

// File: rtl/irq_chain_arbiter_chk.sv
module irq_chain_arbiter_chk (
  input logic        clk,
  input logic        rst,
  input logic        ack_valid,
  input logic        pending,
  input logic        vec_valid,
  input logic [15:0] in_service
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pending && !vec_valid && in_service == 16'h0)); // R1
  AST_VALID_TRACKS_PENDING: assert property (@(posedge clk) disable iff (rst)
    vec_valid == pending); // R4
  AST_ISR_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
    (($past(in_service) & ~in_service) == 16'h0)); // R7
  AST_ISR_ONE_PER_ACK: assert property (@(posedge clk) disable iff (rst)
    $countones(in_service ^ $past(in_service)) <= 1); // R6
  AST_ISR_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    !$past(ack_valid) |-> $stable(in_service)); // R7
endmodule

bind irq_chain_arbiter irq_chain_arbiter_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ack_valid  (ack_valid),
  .pending    (pending),
  .vec_valid  (vec_valid),
  .in_service (in_service)
);

// File: tb/irq_chain_arbiter_test.sv
module irq_chain_arbiter_test;
  logic        clk = 0, rst = 1;
  logic [15:0] req_raise = 0, req_lower = 0;
  logic [7:0]  mask_b0 = 0, mask_b1 = 0, base_b0 = 8'h20, base_b1 = 8'h70;
  logic        ack_valid = 0, cfg_we = 0, cfg_sel = 0;
  logic [7:0]  ack_vec = 0, cfg_wdata = 0;
  logic [7:0]  cfg_rdata, vec_out;
  logic        pending, vec_valid;
  logic [15:0] in_service;
  int errors = 0, checks = 0;
  bit started = 0;

  always #5 clk = ~clk;

  irq_chain_arbiter uut (.clk(clk), .rst(rst), .req_raise(req_raise), .req_lower(req_lower),
    .mask_b0(mask_b0), .mask_b1(mask_b1), .base_b0(base_b0), .base_b1(base_b1),
    .ack_valid(ack_valid), .ack_vec(ack_vec), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pending(pending),
    .vec_valid(vec_valid), .vec_out(vec_out), .in_service(in_service));

  // behavioural reference model
  bit [15:0] mreq, misr;
  bit [7:0]  mtrig [2];
  bit        e_pend, e_valid;
  bit [7:0]  e_vec, e_rd;

  always @(posedge clk) begin
    bit [15:0] live, r, l;
    int line;
    started = 1;
    if (rst) begin
      mreq = 0; misr = 0; mtrig[0] = 0; mtrig[1] = 0;
      e_pend = 0; e_valid = 0; e_vec = 0; e_rd = 0;
    end else begin
      live = mreq & ~{mask_b1, mask_b0};
      e_pend = (live != 0); e_valid = 0; e_vec = 0;
      for (int i = 15; i >= 0; i--)
        if (live[i]) begin
          e_valid = 1;
          e_vec = (i < 8) ? base_b0 + 8'(i) : base_b1 + 8'(i - 8);
        end
      e_rd = mtrig[cfg_sel];
      if (ack_valid) begin
        line = -1;
        if (int'(ack_vec) >= int'(base_b0) && int'(ack_vec) <= int'(base_b0) + 7) line = int'(ack_vec) % 8;
        else if (int'(ack_vec) >= int'(base_b1) && int'(ack_vec) <= int'(base_b1) + 7) line = 8 + int'(ack_vec) % 8;
        if (line >= 0 && live[line]) begin
          misr[line] = 1;
          if (!mtrig[line / 8][line % 8]) mreq[line] = 0;
        end
      end
      r = req_raise; l = req_lower;
      if (r[2]) r[9] = 1;
      if (l[2]) l[9] = 1;
      r[2] = 0; l[2] = 0;
      mreq = (mreq & ~l) | r;
      if (cfg_we) mtrig[cfg_sel] = cfg_wdata;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("R2 pending", pending, e_pend);
    chk("R4 vec_valid", vec_valid, e_valid);
    if (e_valid) chk("R3 vec_out", vec_out, e_vec);
    chk("R7 in_service", in_service, misr);
    chk("R9 cfg_rdata", cfg_rdata, e_rd);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raise_line(input int i);
    req_raise[i] = 1; cyc(1); req_raise = 0;
  endtask

  task automatic lower_line(input int i);
    req_lower[i] = 1; cyc(1); req_lower = 0;
  endtask

  task automatic ack(input logic [7:0] v);
    ack_valid = 1; ack_vec = v; cyc(1); ack_valid = 0;
  endtask

  task automatic wr_trig(input bit s, input logic [7:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d; cyc(1); cfg_we = 0;
  endtask

  initial begin
    cyc(3); rst = 0; cyc(1);
    chk("R1 pending after reset", pending, 0);
    chk("R1 isr after reset", in_service, 0);
    chk("R1 rdata after reset", cfg_rdata, 0);
    // R9: trigger bytes; line 9 and line 4 level
    wr_trig(1, 8'h02); wr_trig(0, 8'h10);
    cfg_sel = 0; cyc(2); chk("R9 read bank0", cfg_rdata, 8'h10);
    cfg_sel = 1; cyc(2); chk("R9 read bank1", cfg_rdata, 8'h02);
    // R3: bank0 beats bank1
    req_raise[5] = 1; req_raise[12] = 1; cyc(1); req_raise = 0; cyc(1);
    chk("R3 lowest wins", vec_out, 8'h25);
    mask_b0 = 8'h20; cyc(2);
    chk("R4 bank1 vector", vec_out, 8'h74);
    // R6: out-of-range vector ignored
    ack(8'h55); cyc(1);
    chk("R6 bad vector no isr", in_service, 0);
    chk("R6 bad vector keeps request", vec_out, 8'h74);
    // R8 edge line clears request
    ack(8'h74); cyc(1);
    chk("R6 isr line 12", in_service, 16'h1000);
    chk("R8 edge request cleared", pending, 0);
    // R7: ack of masked line ignored
    ack(8'h25); cyc(1);
    chk("R7 masked ack ignored", in_service, 16'h1000);
    // R5: cascade input 2 goes to line 9
    raise_line(2); cyc(1);
    chk("R5 cascade vector", vec_out, 8'h71);
    ack(8'h71); cyc(1);
    chk("R8 level keeps request", vec_out, 8'h71);
    chk("R8 isr line 9", in_service, 16'h1200);
    // R10: lower clears
    lower_line(9); cyc(1);
    chk("R10 lower clears", pending, 0);
    mask_b0 = 0; cyc(2);
    chk("R3 unmasked line 5", vec_out, 8'h25);
    lower_line(5);
    // R10: raise and ack on same edge line
    raise_line(3); cyc(1);
    req_raise[3] = 1; ack_valid = 1; ack_vec = 8'h23; cyc(1);
    req_raise = 0; ack_valid = 0; cyc(1);
    chk("R10 raise beats ack", vec_out, 8'h23);
    chk("R10 isr line 3", in_service, 16'h1208);
    // R10: raise beats lower
    req_raise[6] = 1; req_lower[6] = 1; cyc(1); req_raise = 0; req_lower = 0;
    mask_b0 = 8'h08; cyc(2);
    chk("R10 raise beats lower", vec_out, 8'h26);
    // R6 overlapping ranges: bank0 takes priority
    base_b1 = 8'h20; cyc(2); ack(8'h26); cyc(1);
    chk("R6 overlap goes to bank0", in_service, 16'h1248);
    cyc(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule